// File: doc/BRIEF.md
# Register-Overlaid RAM Bank Mapper

This block is the address-mapping controller of a game cartridge for an 8-bit console. It watches the 16-bit CPU bus and the picture-processor bus. It produces the chip selects and the upper address lines for an external program ROM, a character ROM and an 8 KiB work RAM. The CPU sees the work RAM at `$6000-$7FFF`. It sees one 32 KiB program-ROM bank at `$8000-$FFFF`. The picture bus sees two 4 KiB character banks that are selected independently, one at `$0000-$0FFF` and one at `$1000-$1FFF`.

The three bank registers live at the top three bytes of the RAM window:

| Address | Register contents |
|---------|-------------------|
| `$7FFD` | program bank |
| `$7FFE` | low character bank |
| `$7FFF` | high character bank |

A CPU store to one of these addresses does two things in the same cycle: it goes to RAM as a normal write, and it loads the register. A CPU load from the same address is served by the RAM alone, so it returns the byte that was stored there last. Nametable mirroring is fixed: the two nametables are stacked vertically. The memory arrays themselves are outside the block.

Top module: `ram_overlay_mapper`

## Requirements
- R1: Any CPU access to `$6000-$7FFF` asserts `ram_ce_o`. `ram_we_o` is asserted only when such an access is a write (`cpu_rw_i`=0). Both stay low outside that range.
- R2: A CPU read in `$8000-$FFFF` asserts `prg_ce_o`. `prg_addr_hi_o` always drives the current program bank, whose bit 1 is ROM A16 and bit 0 is ROM A15. A write in that range asserts no select.
- R3: A CPU write to exactly `$7FFD` loads data bits 1:0 into the program bank. The load happens unmasked on the clock edge of the write and is visible from the next cycle. Data bits 7:2 are ignored.
- R4: A CPU write to exactly `$7FFE` loads data bits 3:0 into the low character bank. `chr_addr_hi_o` (A15:A12) equals this bank whenever picture address bit 12 is 0.
- R5: A CPU write to exactly `$7FFF` loads data bits 3:0 into the high character bank. `chr_addr_hi_o` equals this bank whenever picture address bit 12 is 1.
- R6: A register write also writes the RAM (`ram_ce_o` and `ram_we_o` high). A read of `$7FFD-$7FFF` selects the RAM, returns the last byte written there, and leaves every bank unchanged.
- R7: Register decode compares all 16 address bits. Writes to any other address, for example `$7FFC`, `$FFFD`, `$5FFD`, `$3FFD` or `$8000`, change no bank.
- R8: `chr_ce_o` is high for picture addresses below `$2000`. `nt_a10_o` equals picture address bit 11, which gives horizontal mirroring.
- R9: With the 64 KiB program-ROM option, `prg_addr_hi_o[1]` is always 0. Bit 0 then follows data bit 0 of the last `$7FFD` write.
- R10: Reset (`rst_ni` low) clears all three banks to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | CPU bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_addr_i | input | 16 | CPU address |
| cpu_data_i | input | 8 | CPU write data |
| cpu_rw_i | input | 1 | 1 = read, 0 = write |
| ppu_addr_i | input | 14 | Picture-bus address |
| ram_ce_o | output | 1 | Work RAM select |
| ram_we_o | output | 1 | Work RAM write enable |
| prg_ce_o | output | 1 | Program ROM select |
| prg_addr_hi_o | output | 2 | Program ROM A16:A15 |
| chr_ce_o | output | 1 | Character ROM select |
| chr_addr_hi_o | output | 4 | Character ROM A15:A12 |
| nt_a10_o | output | 1 | Nametable RAM A10 |

## Verification
The hardest case to reach is the overlap itself. It needs a write that must land in the RAM model and load a register in the same edge. Later it needs a read of the same address that must return the RAM byte and leave the banks alone. The stimulus therefore writes bytes to each register address whose upper bits differ from the bank value. It reads those addresses back from the bench RAM model and sweeps the picture address across both character halves after every change.

A second pass sends writes to near-miss addresses that differ from a register address in a single nibble. A biased random phase then mixes register hits, RAM and ROM traffic against a 64 KiB and a 128 KiB instance side by side.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  localparam int unsigned CPU_AW    = 16;
  localparam int unsigned PPU_AW    = 14;
  localparam int unsigned PRG_HI_W  = 2;
  localparam int unsigned CHR_HI_W  = 4;
  localparam logic [CPU_AW-1:0] REG_PRG_ADDR  = 16'h7FFD;
  localparam logic [CPU_AW-1:0] REG_CHR0_ADDR = 16'h7FFE;
  localparam logic [CPU_AW-1:0] REG_CHR1_ADDR = 16'h7FFF;
  localparam logic [2:0] RAM_TAG = 3'b011;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_PRG  = 2'd1,
    SEL_CHR0 = 2'd2,
    SEL_CHR1 = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/cpu_decode.sv
module cpu_decode
  import mapper_pkg::*;
(
  input  logic [CPU_AW-1:0] cpu_addr_i,
  input  logic              cpu_rw_i,
  output logic              ram_sel_o,
  output logic              ram_wr_o,
  output logic              rom_sel_o,
  output logic              reg_wr_o,
  output reg_sel_e          reg_sel_o
);
  always_comb begin
    ram_sel_o = (cpu_addr_i[15:13] == RAM_TAG);
    ram_wr_o  = ram_sel_o && !cpu_rw_i;
    rom_sel_o = cpu_addr_i[15] && cpu_rw_i;
    unique case (cpu_addr_i)
      REG_PRG_ADDR:  reg_sel_o = SEL_PRG;
      REG_CHR0_ADDR: reg_sel_o = SEL_CHR0;
      REG_CHR1_ADDR: reg_sel_o = SEL_CHR1;
      default:       reg_sel_o = SEL_NONE;
    endcase
    reg_wr_o = !cpu_rw_i && (reg_sel_o != SEL_NONE);
  end

  // register writes are always RAM writes too
  always_comb begin
    assert_reg_in_ram_R6: assert (!reg_wr_o || ram_wr_o);
  end
endmodule

// File: rtl/bank_regs.sv
module bank_regs
  import mapper_pkg::*;
#(
  parameter int unsigned PRG_W = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_wr_i,
  input  reg_sel_e            reg_sel_i,
  input  logic [7:0]          data_i,
  output logic [PRG_W-1:0]    prg_bank_o,
  output logic [CHR_HI_W-1:0] chr0_bank_o,
  output logic [CHR_HI_W-1:0] chr1_bank_o
);
  logic unused_data_hi;
  assign unused_data_hi = ^data_i[7:CHR_HI_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prg_bank_o  <= '0;
      chr0_bank_o <= '0;
      chr1_bank_o <= '0;
    end else if (reg_wr_i) begin
      unique case (reg_sel_i)
        SEL_PRG:  prg_bank_o  <= data_i[PRG_W-1:0];
        SEL_CHR0: chr0_bank_o <= data_i[CHR_HI_W-1:0];
        SEL_CHR1: chr1_bank_o <= data_i[CHR_HI_W-1:0];
        default: ;
      endcase
    end
  end

  assert_prg_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_sel_i == SEL_PRG) |=> prg_bank_o == $past(data_i[PRG_W-1:0]));
  assert_chr0_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_sel_i == SEL_CHR0) |=> chr0_bank_o == $past(data_i[CHR_HI_W-1:0]));
  assert_chr1_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_sel_i == SEL_CHR1) |=> chr1_bank_o == $past(data_i[CHR_HI_W-1:0]));
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_wr_i |=> ($stable(prg_bank_o) && $stable(chr0_bank_o) && $stable(chr1_bank_o)));
endmodule

// File: rtl/chr_window.sv
module chr_window
  import mapper_pkg::*;
(
  input  logic [PPU_AW-1:0]   ppu_addr_i,
  input  logic [CHR_HI_W-1:0] chr0_bank_i,
  input  logic [CHR_HI_W-1:0] chr1_bank_i,
  output logic                chr_ce_o,
  output logic [CHR_HI_W-1:0] chr_addr_hi_o,
  output logic                nt_a10_o
);
  logic unused_ppu_lo;
  assign unused_ppu_lo = ^ppu_addr_i[10:0];

  always_comb begin
    chr_ce_o      = !ppu_addr_i[13];
    chr_addr_hi_o = ppu_addr_i[12] ? chr1_bank_i : chr0_bank_i;
    nt_a10_o      = ppu_addr_i[11];  // horizontal mirroring: nametables stacked
  end
endmodule

// File: rtl/ram_overlay_mapper.sv
module ram_overlay_mapper
  import mapper_pkg::*;
#(
  parameter int unsigned PRG_KIB = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       cpu_addr_i,
  input  logic [7:0]        cpu_data_i,
  input  logic              cpu_rw_i,
  input  logic [13:0]       ppu_addr_i,
  output logic              ram_ce_o,
  output logic              ram_we_o,
  output logic              prg_ce_o,
  output logic [1:0]        prg_addr_hi_o,
  output logic              chr_ce_o,
  output logic [3:0]        chr_addr_hi_o,
  output logic              nt_a10_o
);
  localparam int unsigned PRG_W = (PRG_KIB > 64) ? 2 : 1;

  logic          reg_wr;
  reg_sel_e      reg_sel;
  logic [PRG_W-1:0]    prg_bank;
  logic [CHR_HI_W-1:0] chr0_bank, chr1_bank;

  cpu_decode u_dec (
    .cpu_addr_i (cpu_addr_i),
    .cpu_rw_i   (cpu_rw_i),
    .ram_sel_o  (ram_ce_o),
    .ram_wr_o   (ram_we_o),
    .rom_sel_o  (prg_ce_o),
    .reg_wr_o   (reg_wr),
    .reg_sel_o  (reg_sel)
  );

  bank_regs #(.PRG_W(PRG_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_wr_i    (reg_wr),
    .reg_sel_i   (reg_sel),
    .data_i      (cpu_data_i),
    .prg_bank_o  (prg_bank),
    .chr0_bank_o (chr0_bank),
    .chr1_bank_o (chr1_bank)
  );

  generate
    if (PRG_W == 2) begin : g_prg128
      assign prg_addr_hi_o = prg_bank;
    end else begin : g_prg64
      assign prg_addr_hi_o = {1'b0, prg_bank};
    end
  endgenerate

  chr_window u_chr (
    .ppu_addr_i    (ppu_addr_i),
    .chr0_bank_i   (chr0_bank),
    .chr1_bank_i   (chr1_bank),
    .chr_ce_o      (chr_ce_o),
    .chr_addr_hi_o (chr_addr_hi_o),
    .nt_a10_o      (nt_a10_o)
  );

  assert_ram_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (ram_ce_o && !cpu_rw_i && cpu_addr_i[15:13] == 3'b011));
  assert_sel_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_ce_o && prg_ce_o));
  assert_rom_no_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_rw_i |-> !prg_ce_o);
  assert_reg_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_rw_i && ram_ce_o) |=> $stable(prg_addr_hi_o));
endmodule

// File: tb/ram_overlay_mapper_tb.sv
module ram_overlay_mapper_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [15:0] a = 16'h0000;
  logic [7:0]  d = 8'h00;
  logic        rw = 1'b1;
  logic [13:0] p = 14'h0000;

  logic ram_ce, ram_we, prg_ce, chr_ce, nt;
  logic [1:0] prg_hi;
  logic [3:0] chr_hi;
  logic ram_ce64, ram_we64, prg_ce64, chr_ce64, nt64;
  logic [1:0] prg_hi64;
  logic [3:0] chr_hi64;

  int n_tests = 0, n_fail = 0;
  int m_prg = 0, m_c0 = 0, m_c1 = 0;
  logic [7:0] tb_ram [0:8191];
  int shadow [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  ram_overlay_mapper #(.PRG_KIB(128)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_addr_i(a), .cpu_data_i(d), .cpu_rw_i(rw),
    .ppu_addr_i(p), .ram_ce_o(ram_ce), .ram_we_o(ram_we), .prg_ce_o(prg_ce),
    .prg_addr_hi_o(prg_hi), .chr_ce_o(chr_ce), .chr_addr_hi_o(chr_hi), .nt_a10_o(nt));

  ram_overlay_mapper #(.PRG_KIB(64)) u_dut64 (
    .clk_i(clk), .rst_ni(rst_n), .cpu_addr_i(a), .cpu_data_i(d), .cpu_rw_i(rw),
    .ppu_addr_i(p), .ram_ce_o(ram_ce64), .ram_we_o(ram_we64), .prg_ce_o(prg_ce64),
    .prg_addr_hi_o(prg_hi64), .chr_ce_o(chr_ce64), .chr_addr_hi_o(chr_hi64), .nt_a10_o(nt64));

  // external RAM model, written through the DUT's selects
  always @(posedge clk) if (ram_ce && ram_we) tb_ram[a[12:0]] <= d;

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (a=%h rw=%b p=%h)", tag, act, exp, a, rw, p);
    end
  endtask

  task automatic compare();
    bit in_ram = (a >= 16'h6000 && a <= 16'h7FFF);
    check("R1 ram_ce", ram_ce, in_ram);
    check("R1 ram_we", ram_we, in_ram && !rw);
    check("R2 prg_ce", prg_ce, a[15] && rw);
    check("R2 R3 prg_hi", prg_hi, m_prg);
    check("R9 prg_hi 64k", prg_hi64, m_prg & 1);
    check("R8 chr_ce", chr_ce, !p[13]);
    check(p[12] ? "R5 chr_hi" : "R4 chr_hi", chr_hi, p[12] ? m_c1 : m_c0);
    check("R8 nt_a10", nt, p[11]);
    check("R9 chr_hi 64k", chr_hi64, p[12] ? m_c1 : m_c0);
    if (rw && in_ram && shadow.exists(int'(a[12:0])))
      check("R6 ram readback", tb_ram[a[12:0]], shadow[int'(a[12:0])]);
  endtask

  // one bus cycle: inputs already set after a negedge
  task automatic step();
    #(CLK_PERIOD/4);
    compare();
    @(posedge clk);
    if (rst_n && !rw) begin
      if (a >= 16'h6000 && a <= 16'h7FFF) shadow[int'(a[12:0])] = d;
      if (a == 16'h7FFD) m_prg = d & 3;
      if (a == 16'h7FFE) m_c0 = d & 15;
      if (a == 16'h7FFF) m_c1 = d & 15;
    end
    @(negedge clk);
  endtask

  task automatic cyc(logic [15:0] aa, logic [7:0] dd, logic r, logic [13:0] pp);
    a = aa; d = dd; rw = r; p = pp;
    step();
  endtask

  task automatic sweep_ppu();
    foreach (sweep_pts[i]) cyc(16'h0000, 8'h00, 1'b1, sweep_pts[i]);
  endtask
  logic [13:0] sweep_pts [8] = '{14'h0000, 14'h0FFF, 14'h1000, 14'h1FFF,
                                 14'h2000, 14'h2400, 14'h2800, 14'h2C00};

  task automatic finish_tb();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_tb();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 prg reset", prg_hi, 0);
    check("R10 chr reset", chr_hi, 0);
    rst_n = 1;
    @(negedge clk);
    sweep_ppu();
    // R3 R4 R5: loads, upper data bits ignored
    cyc(16'h7FFD, 8'hFE, 1'b0, 14'h0000);
    cyc(16'h8000, 8'h00, 1'b1, 14'h0000);
    cyc(16'h7FFE, 8'hA5, 1'b0, 14'h0000);
    cyc(16'h7FFF, 8'h3C, 1'b0, 14'h1000);
    sweep_ppu();
    cyc(16'h7FFD, 8'hFF, 1'b0, 14'h0000);
    cyc(16'hC123, 8'h00, 1'b1, 14'h1000);
    // R6: reads of register addresses return RAM bytes, banks unchanged
    cyc(16'h7FFD, 8'h00, 1'b1, 14'h0000);
    cyc(16'h7FFE, 8'h00, 1'b1, 14'h0000);
    cyc(16'h7FFF, 8'h00, 1'b1, 14'h1000);
    check("R6 bank after read", prg_hi, 3);
    // R7: near-miss writes change nothing
    cyc(16'h7FFC, 8'h00, 1'b0, 14'h0000);
    cyc(16'hFFFD, 8'h00, 1'b0, 14'h0000);
    cyc(16'h5FFD, 8'h00, 1'b0, 14'h0000);
    cyc(16'h3FFD, 8'h00, 1'b0, 14'h0000);
    cyc(16'h8000, 8'h00, 1'b0, 14'h0000);
    cyc(16'h7EFE, 8'h00, 1'b0, 14'h0000);
    cyc(16'hFFFF, 8'h00, 1'b0, 14'h1000);
    sweep_ppu();
    check("R7 prg held", prg_hi, 3);
    // R1: plain RAM use
    cyc(16'h6000, 8'h5A, 1'b0, 14'h0000);
    cyc(16'h6000, 8'h00, 1'b1, 14'h0000);
    cyc(16'h7FFC, 8'h00, 1'b1, 14'h0000);
    // biased random mix
    for (int i = 0; i < 2000; i++) begin
      logic [15:0] ra;
      int k = $urandom_range(0, 9);
      case (k)
        0: ra = 16'h7FFD;
        1: ra = 16'h7FFE;
        2: ra = 16'h7FFF;
        3: ra = 16'h7FFC;
        4: ra = 16'h6000 + 16'($urandom_range(0, 8191));
        5: ra = 16'h8000 + 16'($urandom_range(0, 32767));
        default: ra = 16'($urandom_range(0, 65535));
      endcase
      cyc(ra, 8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)),
          14'($urandom_range(0, 16383)));
    end
    // R10: reset again clears banks
    rst_n = 0;
    m_prg = 0; m_c0 = 0; m_c1 = 0;
    #1;
    check("R10 prg async reset", prg_hi, 0);
    check("R10 chr async reset", chr_hi, p[12] ? 0 : 0);
    finish_tb();
  end
endmodule